// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Serial Bus

This block is a target on a two-wire SMBus/I2C-style serial bus. It gives a host read and write access to a small bank of 8-bit configuration registers. SCL and SDA are sampled through synchronizers in the system clock domain. SDA is driven only as an open-drain pull-down enable. The target's 7-bit device address takes its upper six bits from a parameter and its lowest bit from an address-select pin, which is captured while reset is held.

Every transfer names a starting index. A write carries a starting index, then a byte count, then the data bytes. A read first sets the index in a write phase, then issues a repeated start with the read bit set. The target then returns a byte count, taken from a count register kept at the top of the bank, followed by register contents. The rest of the chip sees the whole bank at once on a flat parallel output, plus a one-cycle strobe for every register write that takes effect.

Top module: `smbus_blkreg_target`

## Requirements
- R1: The device address is {ADDR_BASE[6:1], level of addr_sel while rst_n was low}. A later change of addr_sel has no effect. An address byte (7-bit address in bits 7..1, read=1/write=0 in bit 0) is acknowledged (SDA pulled low during the ninth clock) only when its address matches.
- R2: In a write, the host sends the address with the write bit, an index byte N, a count byte X, and then data bytes. Data byte k lands in register N+k. Each write that lands gives one wr_stb pulse carrying its index and data.
- R3: The target acknowledges the address, the index, the count and every data byte of a write.
- R4: Data bytes sent after X bytes have already been taken are acknowledged but change no register and give no strobe.
- R5: Data bytes aimed at an index at or above NUM_REGS are acknowledged but discarded, with no strobe.
- R6: After a repeated start and a matching address with the read bit, the first byte the target sends is the count register (index NUM_REGS-1). The index set by the preceding write phase is kept across the repeated start.
- R7: After the count, the target sends register N, N+1, and so on, one per host acknowledge. Indices at or above NUM_REGS read as 0x00.
- R8: After the host not-acknowledges a byte, the target keeps SDA released until the next start or stop.
- R9: A start or stop at any point aborts the current transfer. A non-matching address leaves SDA released for the rest of that transfer.
- R10: The target changes its SDA drive only while SCL is low.
- R11: After reset, SDA is released, every register reads 0x00, and the count register reads NUM_REGS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel | input | 1 | Address-select pin, captured while in reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| regs_o | output | NUM_REGS*8 | Register bank; register i at bits 8i+7..8i |
| wr_stb | output | 1 | One-cycle pulse per register write that lands |
| wr_idx | output | 8 | Index of the register written with wr_stb |
| wr_data | output | 8 | Data written with wr_stb |

## Verification
A wrong bit counter or phase in the controller shows at the ports within one bus byte. The acknowledge then lands on the wrong clock, or is missing, and the bench samples it in the middle of the ninth SCL high phase. A corrupted index or count shows on regs_o and on the wr_stb count right after the byte that used it. In a read, it shows in the value of the next byte sent. A target that fails to go quiet after a not-acknowledge or a mismatch is caught on the next clocked byte, which then reads back other than 0xFF.

// File: rtl/smb_pkg.sv
// Shared types for the indexed block register target.
// Assumes: nothing beyond IEEE 1800-2017.
package smb_pkg;

    // Bit-level state of the transfer controller
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a start
        ST_RX,      // shifting in a byte from the host
        ST_ACK,     // target holding SDA low for the ninth clock
        ST_TX,      // shifting out a byte to the host
        ST_HACK,    // waiting for the host's acknowledge bit
        ST_HNEXT,   // host acknowledged, load next byte at SCL fall
        ST_IGNORE   // released, waiting for start or stop
    } smb_state_e;

    // Which byte of a transfer is being received
    typedef enum logic [1:0] {
        PH_ADDR,
        PH_IDX,
        PH_CNT,
        PH_DATA
    } smb_phase_e;

endpackage

// File: rtl/smb_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain, then derives
// SCL edges and start/stop conditions from the synchronized levels.
// Assumes: the bus is slow compared with clk (each SCL phase lasts several
// clk cycles), and both lines idle high.
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES:0] scl_pipe;
    logic [SYNC_STAGES:0] sda_pipe;
    logic                 scl_q;
    logic                 sda_q;

    // Synchronizer chains plus one history stage, idle-high reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_in};
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];
    assign scl_q = scl_pipe[SYNC_STAGES];
    assign sda_q = sda_pipe[SYNC_STAGES];

    // Edge and bus-condition decode on the synchronized levels
    always_comb begin
        scl_rise  = scl_s && !scl_q;
        scl_fall  = !scl_s && scl_q;
        start_det = scl_s && scl_q && sda_q && !sda_s;
        stop_det  = scl_s && scl_q && !sda_q && sda_s;
    end

endmodule

// File: rtl/smb_reg_bank.sv
// Bank of 8-bit registers with one write port and one read port.
// The top register holds the read byte count and resets to COUNT_RESET.
// Writes and reads at indices at or above NUM_REGS are dropped or
// return zero.
// Assumes: NUM_REGS between 1 and 255.
module smb_reg_bank #(
    parameter int         NUM_REGS    = 8,
    parameter logic [7:0] COUNT_RESET = 8'd8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [7:0]            widx,
    input  logic [7:0]            wdata,
    input  logic [7:0]            ridx,
    output logic [7:0]            rdata,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    localparam int CNT_SLOT = NUM_REGS - 1;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [7:0] RST_VAL = (i == CNT_SLOT) ? COUNT_RESET : 8'h00;
        logic [7:0] q;

        // One register: reset value, then write when addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= RST_VAL;
            end else if (we && widx == 8'(i)) begin
                q <= wdata;
            end
        end

        assign regs_flat[i*8 +: 8] = q;

        AST_REG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (we && widx == 8'(i)) |=> (q == $past(wdata))); // R2
    end

    // Read mux; indices outside the bank give zero
    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ridx == 8'(i)) begin
                rdata = regs_flat[i*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/smb_xfer_ctrl.sv
// Bit- and byte-level controller for indexed block write and read.
// Receives bits on SCL rise, drives SDA on SCL fall, tracks index and
// remaining write count, and produces register write requests.
// Assumes: synchronized inputs from smb_line_sync; rd_data is a
// combinational function of rd_ptr.
module smb_xfer_ctrl
    import smb_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [6:0] dev_addr,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_ptr,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] wr_ptr,
    output logic [7:0] wr_byte
);

    localparam logic [7:0] CNT_PTR = 8'(NUM_REGS - 1);
    localparam logic [8:0] LIMIT   = 9'(NUM_REGS);

    smb_state_e state;
    smb_phase_e phase;
    logic [3:0] bitcnt;
    logic [6:0] shreg;
    logic [6:0] tx_sh;
    logic [7:0] idx;
    logic [7:0] remain;
    logic       ack_ok;
    logic       rd_mode;
    logic       cnt_pend;
    logic [7:0] rx_byte;
    logic       idx_in_range;

    assign rx_byte      = {shreg, sda_s};
    assign idx_in_range = ({1'b0, idx} < LIMIT);
    assign rd_ptr       = cnt_pend ? CNT_PTR : idx;

    // Main sequencer: bus conditions first, then per-state bit handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= PH_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            tx_sh    <= '0;
            idx      <= '0;
            remain   <= '0;
            ack_ok   <= 1'b0;
            rd_mode  <= 1'b0;
            cnt_pend <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_ptr   <= '0;
            wr_byte  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state  <= ST_RX;
                phase  <= PH_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= rx_byte[6:0];
                            bitcnt <= bitcnt + 4'd1;
                            if (bitcnt == 4'd7) begin
                                // full byte present: decode by phase
                                case (phase)
                                    PH_ADDR: begin
                                        if (rx_byte[7:1] == dev_addr) begin
                                            ack_ok   <= 1'b1;
                                            rd_mode  <= rx_byte[0];
                                            cnt_pend <= rx_byte[0];
                                            phase    <= PH_IDX;
                                        end else begin
                                            ack_ok <= 1'b0;
                                        end
                                    end
                                    PH_IDX: begin
                                        idx    <= rx_byte;
                                        ack_ok <= 1'b1;
                                        phase  <= PH_CNT;
                                    end
                                    PH_CNT: begin
                                        remain <= rx_byte;
                                        ack_ok <= 1'b1;
                                        phase  <= PH_DATA;
                                    end
                                    default: begin
                                        ack_ok <= 1'b1;
                                        idx    <= idx + 8'd1;
                                        if (remain != 8'd0) begin
                                            remain <= remain - 8'd1;
                                            if (idx_in_range) begin
                                                wr_en   <= 1'b1;
                                                wr_ptr  <= idx;
                                                wr_byte <= rx_byte;
                                            end
                                        end
                                    end
                                endcase
                            end
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (ack_ok) begin
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ACK, ST_HNEXT: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (state == ST_HNEXT || rd_mode) begin
                                // load the next byte to send and drive its MSB
                                tx_sh  <= rd_data[6:0];
                                sda_oe <= !rd_data[7];
                                state  <= ST_TX;
                                if (cnt_pend) begin
                                    cnt_pend <= 1'b0;
                                end else begin
                                    idx <= idx + 8'd1;
                                end
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_HACK;
                            end else begin
                                sda_oe <= !tx_sh[6];
                                tx_sh  <= {tx_sh[5:0], 1'b0};
                            end
                        end
                    end
                    ST_HACK: begin
                        if (scl_rise) begin
                            state <= sda_s ? ST_IGNORE : ST_HNEXT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s); // R10

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe)); // R9

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe); // R8

    AST_WRITE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (phase == PH_DATA && {1'b0, wr_ptr} < LIMIT)); // R5

    AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && state == ST_ACK) |-> ($past(bitcnt) == 4'd8)); // R3

endmodule

// File: rtl/smbus_blkreg_target.sv
// Top of the indexed block register target. Captures the address-select
// pin during reset, forms the device address, and connects the line
// synchronizer, the transfer controller and the register bank.
// Assumes: SDA pad is open-drain, driven low when sda_oe is 1.
module smbus_blkreg_target #(
    parameter int         NUM_REGS    = 8,
    parameter logic [6:0] ADDR_BASE   = 7'h6A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  addr_sel,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic                  wr_stb,
    output logic [7:0]            wr_idx,
    output logic [7:0]            wr_data
);

    localparam logic [7:0] COUNT_RESET = 8'(NUM_REGS);

    logic       addr_lat;
    logic [6:0] dev_addr;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] rd_ptr;
    logic [7:0] rd_data;

    // Address-select capture: follows the pin only while in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lat <= addr_sel;
        end
    end

    assign dev_addr = {ADDR_BASE[6:1], addr_lat};

    smb_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    smb_xfer_ctrl #(
        .NUM_REGS(NUM_REGS)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .dev_addr (dev_addr),
        .rd_data  (rd_data),
        .rd_ptr   (rd_ptr),
        .sda_oe   (sda_oe),
        .wr_en    (wr_stb),
        .wr_ptr   (wr_idx),
        .wr_byte  (wr_data)
    );

    smb_reg_bank #(
        .NUM_REGS   (NUM_REGS),
        .COUNT_RESET(COUNT_RESET)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_stb),
        .widx     (wr_idx),
        .wdata    (wr_data),
        .ridx     (rd_ptr),
        .rdata    (rd_data),
        .regs_flat(regs_o)
    );

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(addr_lat)); // R1

endmodule

// File: tb/test_smbus_blkreg_target.sv
`timescale 1ns/1ps
module test_smbus_blkreg_target;

    localparam int NUM_REGS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b1;
    logic scl = 1'b1;
    logic host_oe = 1'b0;
    logic sda_line;
    logic sda_oe;
    logic [NUM_REGS*8-1:0] regs_o;
    logic wr_stb;
    logic [7:0] wr_idx, wr_data;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    int oe_cycles = 0;
    int oe_viol = 0;
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;
    logic [7:0] exp_regs [NUM_REGS];

    always #2 clk = ~clk;

    assign sda_line = !(host_oe || sda_oe);

    smbus_blkreg_target #(.NUM_REGS(NUM_REGS)) i_smbus_blkreg_target (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
        .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .regs_o(regs_o), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    // Monitors: strobes, target drive cycles, drive changes while SCL high
    always @(negedge clk) begin
        if (wr_stb) stb_cnt++;
        if (sda_oe) oe_cycles++;
        if (rst_n && sda_oe != prev_oe && scl && prev_scl) oe_viol++;
        prev_oe  = sda_oe;
        prev_scl = scl;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NUM_REGS; i++)
            check(regs_o[i*8 +: 8] == exp_regs[i], req, regs_o[i*8 +: 8], exp_regs[i]);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_oe = 1'b0; tick(4);
        scl = 1'b1; tick(6);
        host_oe = 1'b1; tick(6);
        scl = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        host_oe = 1'b1; tick(4);
        scl = 1'b1; tick(6);
        host_oe = 1'b0; tick(6);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            host_oe = !b[i]; tick(4);
            scl = 1'b1; tick(8);
            scl = 1'b0; tick(4);
        end
        host_oe = 1'b0; tick(4);
        scl = 1'b1; tick(4);
        acked = !sda_line;
        tick(4);
        scl = 1'b0; tick(4);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        host_oe = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(4);
            scl = 1'b1; tick(4);
            b[i] = sda_line;
            tick(4);
            scl = 1'b0; tick(4);
        end
        host_oe = give_ack; tick(4);
        scl = 1'b1; tick(8);
        scl = 1'b0; tick(4);
        host_oe = 1'b0;
    endtask

    task automatic send_acked(input logic [7:0] b, input string req);
        bit a;
        send_byte(b, a);
        check(a, req, 64'(a), 64'd1);
    endtask

    // R11: reset state
    task automatic t_reset();
        check(sda_oe == 1'b0, "R11 sda released", 64'(sda_oe), 64'd0);
        check_regs("R11 reset values");
    endtask

    // R2/R3: block write of three bytes at index 2
    task automatic t_write();
        int s0 = stb_cnt;
        bus_start();
        send_acked(8'hD6, "R3 address ack");
        send_acked(8'h02, "R3 index ack");
        send_acked(8'h03, "R3 count ack");
        send_acked(8'hA1, "R3 data ack");
        send_acked(8'hB2, "R3 data ack");
        send_acked(8'hC3, "R3 data ack");
        bus_stop();
        exp_regs[2] = 8'hA1; exp_regs[3] = 8'hB2; exp_regs[4] = 8'hC3;
        check_regs("R2 block write");
        check(stb_cnt - s0 == 3, "R2 strobe count", 64'(stb_cnt - s0), 64'd3);
    endtask

    // R6/R7/R8: indexed read with count first, then NACK silences target
    task automatic t_read();
        logic [7:0] b;
        bus_start();
        send_acked(8'hD6, "R6 write address ack");
        send_acked(8'h02, "R6 index ack");
        bus_start();
        send_acked(8'hD7, "R6 read address ack");
        recv_byte(b, 1'b1); check(b == 8'h08, "R6 count byte", 64'(b), 64'h08);
        recv_byte(b, 1'b1); check(b == 8'hA1, "R7 data N", 64'(b), 64'hA1);
        recv_byte(b, 1'b1); check(b == 8'hB2, "R7 data N+1", 64'(b), 64'hB2);
        recv_byte(b, 1'b0); check(b == 8'hC3, "R7 data N+2", 64'(b), 64'hC3);
        recv_byte(b, 1'b0); check(b == 8'hFF, "R8 released after nack", 64'(b), 64'hFF);
        bus_stop();
    endtask

    // R4: bytes after the count are acked but dropped
    task automatic t_extra();
        int s0 = stb_cnt;
        bus_start();
        send_acked(8'hD6, "R4 address ack");
        send_acked(8'h00, "R4 index ack");
        send_acked(8'h01, "R4 count ack");
        send_acked(8'h11, "R4 data ack");
        send_acked(8'h22, "R4 extra byte ack");
        bus_stop();
        exp_regs[0] = 8'h11;
        check_regs("R4 extra byte dropped");
        check(stb_cnt - s0 == 1, "R4 strobe count", 64'(stb_cnt - s0), 64'd1);
    endtask

    // R5: write running past the bank end
    task automatic t_range_write();
        int s0 = stb_cnt;
        bus_start();
        send_acked(8'hD6, "R5 address ack");
        send_acked(8'h06, "R5 index ack");
        send_acked(8'h03, "R5 count ack");
        send_acked(8'h66, "R5 data ack");
        send_acked(8'h05, "R5 data ack");
        send_acked(8'h99, "R5 out-of-range ack");
        bus_stop();
        exp_regs[6] = 8'h66; exp_regs[7] = 8'h05;
        check_regs("R5 range write");
        check(stb_cnt - s0 == 2, "R5 strobe count", 64'(stb_cnt - s0), 64'd2);
    endtask

    // R6/R7: read across the bank end, count register rewritten
    task automatic t_range_read();
        logic [7:0] b;
        bus_start();
        send_acked(8'hD6, "R7 address ack");
        send_acked(8'h06, "R7 index ack");
        bus_start();
        send_acked(8'hD7, "R7 read address ack");
        recv_byte(b, 1'b1); check(b == 8'h05, "R6 written count", 64'(b), 64'h05);
        recv_byte(b, 1'b1); check(b == 8'h66, "R7 reg6", 64'(b), 64'h66);
        recv_byte(b, 1'b1); check(b == 8'h05, "R7 reg7", 64'(b), 64'h05);
        recv_byte(b, 1'b0); check(b == 8'h00, "R7 beyond bank zero", 64'(b), 64'h00);
        bus_stop();
    endtask

    // R1/R9: other address value is not acked, target stays silent
    task automatic t_wrong_addr();
        bit a;
        int o0 = oe_cycles;
        int s0 = stb_cnt;
        bus_start();
        send_byte(8'hD4, a); check(!a, "R1 mismatch not acked", 64'(a), 64'd0);
        send_byte(8'h01, a);
        send_byte(8'h01, a);
        send_byte(8'h77, a);
        bus_stop();
        check(oe_cycles == o0, "R9 no drive on mismatch", 64'(oe_cycles - o0), 64'd0);
        check(stb_cnt == s0, "R9 no write on mismatch", 64'(stb_cnt - s0), 64'd0);
        check_regs("R9 mismatch regs");
    endtask

    // R9: repeated start aborts a write; clocking without start is ignored
    task automatic t_abort();
        bit a;
        bus_start();
        send_acked(8'hD6, "R9 address ack");
        send_acked(8'h00, "R9 index ack");
        send_acked(8'h04, "R9 count ack");
        send_acked(8'hE1, "R9 data ack");
        bus_start();
        send_acked(8'hD6, "R9 restart address ack");
        send_acked(8'h05, "R9 restart index ack");
        send_acked(8'h01, "R9 restart count ack");
        send_acked(8'h5A, "R9 restart data ack");
        bus_stop();
        exp_regs[0] = 8'hE1; exp_regs[5] = 8'h5A;
        check_regs("R9 abort by restart");
        send_byte(8'hD6, a);
        check(!a, "R9 idle after stop", 64'(a), 64'd0);
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < NUM_REGS; i++) exp_regs[i] = 8'h00;
        exp_regs[NUM_REGS-1] = 8'(NUM_REGS);
        tick(5);
        rst_n = 1'b1;
        tick(3);
        addr_sel = 1'b0;   // R1: change after reset must not matter
        tick(5);
        t_reset();
        t_write();
        t_read();
        t_extra();
        t_range_write();
        t_range_read();
        t_wrong_addr();
        t_abort();
        check(oe_viol == 0, "R10 drive change while SCL high", 64'(oe_viol), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule